// File: doc/BRIEF.md
# Host Latch Port

This block gives an external 8-bit host asynchronous read and write access to one data latch, using active-low chip-select, read and write strobes. Inside the chip, a local processor reads what the host wrote from an input latch and loads an output latch that the host reads back. Buffer-full flags, a sticky overflow flag and an interrupt line tell the local side when the host has acted.

The three strobes pass through two-flop synchronizers into the local clock. An access counts once, in the cycle after the synchronized chip-select and strobe are first both seen low. The data-bus output enable does not go through the synchronizers: it follows the raw chip-select and read pins while the port mode is on. When the mode is off, the strobes have no effect and the bus stays released.

Top module: `host_latch_port`

## Requirements
- R1: A synchronous active-low reset clears the input latch, the output latch, the input-full, output-full and overflow flags and the interrupt, and releases the data bus (`host_data_oe` = 0).
- R2: A host write is recognized when synchronized chip-select and write are first both low. The value on `host_data_i` is then captured into the input latch, and `in_full` and `irq` are set, no later than the third clock edge after the pins go low.
- R3: While the mode is on and chip-select and read are both low, `host_data_oe` is 1 and `host_data_o` carries the output latch. Otherwise `host_data_oe` is 0.
- R4: Each low period of chip-select with a strobe counts as one access, however long it lasts. Bus data that changes during a held write is not captured again, and an interrupt cleared during the hold stays clear.
- R5: A one-cycle pulse on `loc_rd_ack` (the local side has read the input latch) clears `in_full`.
- R6: A host write that arrives while `in_full` is set raises `overflow` and overwrites the input latch. `overflow` stays set, even through `loc_rd_ack`, until a pulse on `loc_ovf_clr`.
- R7: A pulse on `loc_wr` loads `loc_wdata` into the output latch and sets `out_full`. `out_full` clears once a host read has finished, meaning chip-select or read has returned high after the read was recognized.
- R8: Every recognized host read or write sets `irq`. A pulse on `loc_irq_clr` clears it.
- R9: While `mode_en` is 0, the host strobes are ignored: no capture, no flag change, no interrupt, and the bus stays released.
- R10: Write or read low while chip-select is high is not an access and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Enables host access to the port |
| host_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_data_i | input | 8 | Data from the host bus |
| host_data_o | output | 8 | Data toward the host bus (output latch) |
| host_data_oe | output | 1 | Bus drive enable for host reads |
| loc_rd_ack | input | 1 | Local side has read the input latch |
| loc_wr | input | 1 | Local load of the output latch |
| loc_wdata | input | 8 | Value for the output latch |
| loc_irq_clr | input | 1 | Clears the interrupt |
| loc_ovf_clr | input | 1 | Clears the overflow flag |
| in_latch | output | 8 | Last byte written by the host |
| in_full | output | 1 | Input latch holds unread data |
| out_full | output | 1 | Output latch not yet read by host |
| overflow | output | 1 | Sticky: a host write hit a full input latch |
| irq | output | 1 | Interrupt toward the local side |

## Verification
The assertions assume that the host keeps `host_data_i` stable from the moment chip-select and write go low until it releases them. They also assume that each strobe low or high period lasts at least three local clocks, so that the synchronizers register every transition. The bench drives every pin on the falling clock edge and holds strobes low for four or more cycles and high for at least four. It never pulses a local control in the same cycle as a host access is recognized, so the priority between the two is never exercised.

// File: rtl/hlp_pkg.sv
// Package of shared types for the host latch port.
// Assumes: nothing beyond IEEE 1800-2017.
package hlp_pkg;
    // One-cycle host access events, in the local clock domain
    typedef struct packed {
        logic wr_start;   // host write recognized
        logic rd_start;   // host read recognized
        logic rd_end;     // host read finished
    } hlp_evt_t;
endpackage

// File: rtl/hlp_sync.sv
// Multi-bit synchronizer: every bit passes through its own flop chain.
// Assumes: the bits are independent, single-bit asynchronous controls.
module hlp_sync #(
    parameter int          WIDTH  = 3,
    parameter int          STAGES = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the asynchronous level through the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[LAST];
    end
endmodule

// File: rtl/hlp_access_det.sv
// Detects the start of host writes and reads, and the end of reads,
// from the synchronized strobes.
// Assumes: inputs are already synchronized, active low.
module hlp_access_det
    import hlp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_en,
    input  logic     cs_s_n,
    input  logic     rd_s_n,
    input  logic     wr_s_n,
    output hlp_evt_t evt
);
    logic wr_cond, rd_cond;
    logic wr_q, rd_q;

    assign wr_cond = mode_en & ~cs_s_n & ~wr_s_n;
    assign rd_cond = mode_en & ~cs_s_n & ~rd_s_n;

    // remember the previous access conditions for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_cond;
            rd_q <= rd_cond;
        end
    end

    assign evt.wr_start = wr_cond & ~wr_q;
    assign evt.rd_start = rd_cond & ~rd_q;
    assign evt.rd_end   = rd_q & ~rd_cond;

    // R4: one access yields exactly one start event
    a_r4_single_wr_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wr_start |=> !evt.wr_start);
    a_r4_single_rd_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rd_start |=> !evt.rd_start);
endmodule

// File: rtl/hlp_regs.sv
// Input and output latches plus status flags and interrupt of the port.
// Assumes: events are single-cycle pulses; host data is stable at wr_start.
module hlp_regs
    import hlp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hlp_evt_t          evt,
    input  logic [DATA_W-1:0] host_data_i,
    input  logic              loc_rd_ack,
    input  logic              loc_wr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_irq_clr,
    input  logic              loc_ovf_clr,
    output logic [DATA_W-1:0] in_latch,
    output logic [DATA_W-1:0] out_latch,
    output logic              in_full,
    output logic              out_full,
    output logic              overflow,
    output logic              irq
);
    // capture host data into the input latch on a recognized write
    always_ff @(posedge clk) begin
        if (!rst_n)            in_latch <= '0;
        else if (evt.wr_start) in_latch <= host_data_i;
    end

    // load the output latch from the local side
    always_ff @(posedge clk) begin
        if (!rst_n)      out_latch <= '0;
        else if (loc_wr) out_latch <= loc_wdata;
    end

    // input-full: set by host write, cleared by local read; write wins
    always_ff @(posedge clk) begin
        if (!rst_n)            in_full <= 1'b0;
        else if (evt.wr_start) in_full <= 1'b1;
        else if (loc_rd_ack)   in_full <= 1'b0;
    end

    // sticky overflow: host write onto unread data
    always_ff @(posedge clk) begin
        if (!rst_n)                                   overflow <= 1'b0;
        else if (evt.wr_start && in_full && !loc_rd_ack) overflow <= 1'b1;
        else if (loc_ovf_clr)                         overflow <= 1'b0;
    end

    // output-full: set by local write, cleared when a host read ends
    always_ff @(posedge clk) begin
        if (!rst_n)          out_full <= 1'b0;
        else if (loc_wr)     out_full <= 1'b1;
        else if (evt.rd_end) out_full <= 1'b0;
    end

    // interrupt on every recognized access; setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)                             irq <= 1'b0;
        else if (evt.wr_start || evt.rd_start)  irq <= 1'b1;
        else if (loc_irq_clr)                   irq <= 1'b0;
    end

    a_r2_write_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wr_start |=> (in_full && irq && in_latch == $past(host_data_i)));
    a_r5_ack_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd_ack && !evt.wr_start) |=> !in_full);
    a_r6_overflow_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.wr_start && in_full && !loc_rd_ack) |=> overflow);
    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !loc_ovf_clr) |=> overflow);
    a_r7_local_write: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr |=> (out_full && out_latch == $past(loc_wdata)));
    a_r8_irq_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rd_start |=> irq);
endmodule

// File: rtl/host_latch_port.sv
// Top of the host latch port: synchronizes the host strobes, detects
// accesses, holds the latches and flags, and drives the bus enable.
// Assumes: host data stable while its write strobe is low; strobe
// periods of at least three local clocks.
module host_latch_port
    import hlp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_data_i,
    output logic [DATA_W-1:0] host_data_o,
    output logic              host_data_oe,
    input  logic              loc_rd_ack,
    input  logic              loc_wr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_irq_clr,
    input  logic              loc_ovf_clr,
    output logic [DATA_W-1:0] in_latch,
    output logic              in_full,
    output logic              out_full,
    output logic              overflow,
    output logic              irq
);
    localparam int NCTRL = 3;

    logic [NCTRL-1:0] strb_s;
    hlp_evt_t         evt;
    logic [DATA_W-1:0] out_latch;

    hlp_sync #(.WIDTH(NCTRL), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({host_cs_n, host_rd_n, host_wr_n}),
        .q_sync  (strb_s)
    );

    hlp_access_det i_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_en (mode_en),
        .cs_s_n  (strb_s[2]),
        .rd_s_n  (strb_s[1]),
        .wr_s_n  (strb_s[0]),
        .evt     (evt)
    );

    hlp_regs #(.DATA_W(DATA_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .host_data_i (host_data_i),
        .loc_rd_ack  (loc_rd_ack),
        .loc_wr      (loc_wr),
        .loc_wdata   (loc_wdata),
        .loc_irq_clr (loc_irq_clr),
        .loc_ovf_clr (loc_ovf_clr),
        .in_latch    (in_latch),
        .out_latch   (out_latch),
        .in_full     (in_full),
        .out_full    (out_full),
        .overflow    (overflow),
        .irq         (irq)
    );

    // drive the bus straight from the raw pins during a host read
    always_comb begin
        host_data_oe = mode_en & ~host_cs_n & ~host_rd_n;
        host_data_o  = out_latch;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!irq && !in_full && !out_full && !overflow && in_latch == '0));
    a_r9_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> !host_data_oe);
    a_r10_no_cs_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> !host_data_oe);
endmodule

// File: tb/test_host_latch_port.sv
`timescale 1ns/1ps
module test_host_latch_port;
    logic       clk = 1'b0;
    logic       rst_n, mode_en;
    logic       host_cs_n, host_rd_n, host_wr_n;
    logic [7:0] host_data_i, host_data_o, loc_wdata, in_latch;
    logic       host_data_oe, loc_rd_ack, loc_wr, loc_irq_clr, loc_ovf_clr;
    logic       in_full, out_full, overflow, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    host_latch_port i_host_latch_port (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_data_i(host_data_i), .host_data_o(host_data_o), .host_data_oe(host_data_oe),
        .loc_rd_ack(loc_rd_ack), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
        .loc_irq_clr(loc_irq_clr), .loc_ovf_clr(loc_ovf_clr),
        .in_latch(in_latch), .in_full(in_full), .out_full(out_full),
        .overflow(overflow), .irq(irq)
    );

    // op codes: 0 host write, 1 host read, 2 local write
    localparam int NV = 7;
    localparam logic [19:0] VEC [NV] = '{
        {4'd0, 8'hA5, 8'hA5},
        {4'd2, 8'h3C, 8'h00},
        {4'd1, 8'h00, 8'h3C},
        {4'd0, 8'h00, 8'h00},
        {4'd0, 8'hFF, 8'hFF},
        {4'd2, 8'h81, 8'h00},
        {4'd1, 8'h00, 8'h81}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d, input logic use_cs);
        @(negedge clk);
        host_cs_n = ~use_cs; host_wr_n = 1'b0; host_data_i = d;
        idle(4);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        idle(4);
    endtask

    task automatic local_write(input logic [7:0] d);
        @(negedge clk) begin loc_wr = 1'b1; loc_wdata = d; end
        @(negedge clk) loc_wr = 1'b0;
        idle(1);
    endtask

    initial begin
        rst_n = 1'b0; mode_en = 1'b1;
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_data_i = 8'h00;
        loc_rd_ack = 1'b0; loc_wr = 1'b0; loc_wdata = 8'h00;
        loc_irq_clr = 1'b0; loc_ovf_clr = 1'b0;
        idle(3);
        // R1: reset state
        chk(in_latch == 8'h00 && host_data_o == 8'h00, "R1 latches", in_latch, 0);
        chk({in_full, out_full, overflow, irq} == 4'b0, "R1 flags",
            {in_full, out_full, overflow, irq}, 0);
        chk(host_data_oe == 1'b0, "R1 bus released", host_data_oe, 0);
        rst_n = 1'b1;
        idle(2);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            logic [3:0] op;
            logic [7:0] d, e;
            {op, d, e} = VEC[v];
            case (op)
                4'd0: begin
                    host_write(d, 1'b1);
                    chk(in_latch == e, "R2 captured data", in_latch, e);
                    chk(in_full == 1'b1, "R2 in_full", in_full, 1);
                    chk(irq == 1'b1, "R8 irq on write", irq, 1);
                    pulse(loc_irq_clr);
                    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
                    pulse(loc_rd_ack);
                    chk(in_full == 1'b0, "R5 ack clears in_full", in_full, 0);
                end
                4'd1: begin
                    @(negedge clk) begin host_cs_n = 1'b0; host_rd_n = 1'b0; end
                    #1;
                    chk(host_data_oe == 1'b1, "R3 oe during read", host_data_oe, 1);
                    chk(host_data_o == e, "R3 read data", host_data_o, e);
                    idle(4);
                    host_cs_n = 1'b1; host_rd_n = 1'b1;
                    #1;
                    chk(host_data_oe == 1'b0, "R3 oe released", host_data_oe, 0);
                    idle(4);
                    chk(out_full == 1'b0, "R7 read clears out_full", out_full, 0);
                    chk(irq == 1'b1, "R8 irq on read", irq, 1);
                    pulse(loc_irq_clr);
                end
                default: begin
                    local_write(d);
                    chk(out_full == 1'b1, "R7 out_full set", out_full, 1);
                    chk(host_data_o == d, "R7 output latch", host_data_o, d);
                end
            endcase
        end

        // R6: overflow on unread data, sticky through ack
        host_write(8'h12, 1'b1);
        chk(overflow == 1'b0, "R6 no overflow on first", overflow, 0);
        host_write(8'h34, 1'b1);
        chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
        chk(in_latch == 8'h34, "R6 overwrite", in_latch, 8'h34);
        pulse(loc_rd_ack);
        chk(overflow == 1'b1, "R6 sticky after ack", overflow, 1);
        pulse(loc_ovf_clr);
        chk(overflow == 1'b0, "R6 cleared", overflow, 0);
        pulse(loc_irq_clr);

        // R4: long held write counts once
        @(negedge clk) begin host_cs_n = 1'b0; host_wr_n = 1'b0; host_data_i = 8'h5A; end
        idle(5);
        host_data_i = 8'hC3;
        pulse(loc_irq_clr);
        idle(10);
        chk(irq == 1'b0, "R4 irq stays clear", irq, 0);
        chk(in_latch == 8'h5A, "R4 single capture", in_latch, 8'h5A);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        idle(4);
        pulse(loc_rd_ack);

        // R10: strobes without chip-select
        host_write(8'h77, 1'b0);
        chk(in_latch == 8'h5A && !in_full, "R10 write ignored", in_latch, 8'h5A);
        chk(irq == 1'b0, "R10 no irq", irq, 0);

        // R9: mode disabled
        mode_en = 1'b0;
        host_write(8'h99, 1'b1);
        chk(in_latch == 8'h5A && !in_full && !irq, "R9 write ignored", in_latch, 8'h5A);
        @(negedge clk) begin host_cs_n = 1'b0; host_rd_n = 1'b0; end
        #1;
        chk(host_data_oe == 1'b0, "R9 bus released", host_data_oe, 0);
        idle(4);
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        idle(4);
        chk(irq == 1'b0, "R9 no irq on read", irq, 0);
        mode_en = 1'b1;

        // R1: reset after activity
        local_write(8'hE7);
        host_write(8'h42, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        chk({in_full, out_full, overflow, irq} == 4'b0 && in_latch == 0 && host_data_o == 0,
            "R1 reset after use", {in_full, out_full, overflow, irq}, 0);
        rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule